// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel of a general-purpose timer. It watches a counter value that comes from outside, together with that counter's direction. From these it builds a registered reference level, `ref_o`, which later stages (polarity, dead time, pad drivers) turn into a pin level. Software programs the channel with a single write strobe. Each write carries the compare value, a 3-bit compare mode, a shadow enable, a fast-trigger enable and a 2-bit I/O select.

The compare mode picks one of three kinds of behaviour:
- an action taken when the counter equals the compare value (set, clear or toggle);
- a static forced level;
- one of two pulse-width modulation polarities that follow the count direction.

With shadowing on, a new compare value waits in a buffer and becomes active at the next update event. This lets a PWM period finish with a consistent threshold. In the PWM modes, a trigger edge can stand in for a compare match when the fast enable is set, which saves the latency of waiting for the counter.

Top module: `oc_channel`

## Requirements
- R1: After reset, `ref_o` is 0, the mode is timing (000), shadow and fast are off, the I/O select is 00, and the active compare value is 0.
- R2: Mode 001 sets `ref_o` to 1, mode 010 clears it to 0, and mode 011 inverts it, in each case on the clock edge where `cnt_i` equals the active compare value; otherwise `ref_o` keeps its level. `ref_o` shows the result from that edge on.
- R3: Mode 100 drives `ref_o` to 0 and mode 101 drives it to 1 at every edge, whatever the counter does.
- R4: Mode 110 counting up (`cnt_up_i`=1) gives `ref_o` = (cnt < cmp). Counting down it gives `ref_o` = !(cnt > cmp).
- R5: Mode 111 gives the inverse of mode 110 in both directions.
- R6: Mode 000 takes no action, and `ref_o` keeps its level.
- R7: A write with `wr_shadow_en_i`=1 puts the value only into the buffer. An update event (`upd_i`) seen while the stored shadow enable is 1 copies the buffer into the active compare value. If a write and an update fall on the same edge, the update copies the old buffer contents.
- R8: A write with `wr_shadow_en_i`=0 loads the active compare value at once, overriding an update on the same edge. The next edge compares against the new value.
- R9: In mode 110 or 111 with the stored fast enable at 1, `trig_i` on an edge gives the match level for that edge. The match level is 0 for mode 110 counting up, 1 for mode 110 counting down, and the inverse of these for mode 111. On the next edge the comparison applies again. Outside these modes, or with fast off, `trig_i` has no effect.
- R10: The I/O select field is written only while `ch_en_i` is 0. A write while `ch_en_i` is 1 leaves the old select in place, but the other fields of that write still take effect.
- R11: While the I/O select is not 00 (one of the three input routings), `ref_o` is driven to 0.
- R12: All fields written at edge k act on `ref_o` from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CW | Counter value |
| cnt_up_i | input | 1 | 1 = counting up, 0 = counting down |
| upd_i | input | 1 | Update-event strobe |
| trig_i | input | 1 | Trigger-edge strobe |
| ch_en_i | input | 1 | Channel enable (locks I/O select) |
| wr_en_i | input | 1 | Write strobe for all fields |
| wr_cmp_i | input | CW | Compare value to write |
| wr_mode_i | input | 3 | Compare mode to write |
| wr_shadow_en_i | input | 1 | Shadow enable to write |
| wr_fast_en_i | input | 1 | Fast trigger enable to write |
| wr_io_sel_i | input | 2 | I/O select to write (00 = output compare) |
| ref_o | output | 1 | Reference output level |

## Verification
The assertions check on every cycle:
- the forced levels and the low level in input routing;
- that `ref_o` holds in timing mode;
- the PWM-0 level in both directions;
- the I/O select lock;
- the two ways the compare value is loaded.

Some behaviours can only be shown by the bench's scenarios. These are the toggle history over many matches, the one-edge fast override followed by the return to comparison, and a shadowed value that stays inactive until an update arrives. The bench covers them by comparing `ref_o` with its own model on every cycle, under random writes, direction changes, updates and triggers.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_TIMING = 3'b000,
    OC_SET    = 3'b001,
    OC_CLR    = 3'b010,
    OC_TGL    = 3'b011,
    OC_LOW    = 3'b100,
    OC_HIGH   = 3'b101,
    OC_PWM_A  = 3'b110,
    OC_PWM_B  = 3'b111
  } oc_mode_e;

  localparam int unsigned IO_W = 2;
  localparam logic [IO_W-1:0] IO_OUT = '0;
endpackage

// File: rtl/oc_ctrl_regs.sv
module oc_ctrl_regs
  import oc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            ch_en_i,
  input  logic [2:0]      wr_mode_i,
  input  logic            wr_shadow_en_i,
  input  logic            wr_fast_en_i,
  input  logic [IO_W-1:0] wr_io_sel_i,
  output oc_mode_e        mode_o,
  output logic            shadow_en_o,
  output logic            fast_en_o,
  output logic [IO_W-1:0] io_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= OC_TIMING;
      shadow_en_o <= 1'b0;
      fast_en_o   <= 1'b0;
    end else if (wr_en_i) begin
      mode_o      <= oc_mode_e'(wr_mode_i);
      shadow_en_o <= wr_shadow_en_i;
      fast_en_o   <= wr_fast_en_i;
    end
  end

  // I/O routing locked while the channel runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   io_sel_o <= IO_OUT;
    else if (wr_en_i && !ch_en_i)  io_sel_o <= wr_io_sel_i;
  end

  a_r10_io_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_en_i |=> $stable(io_sel_o));
  a_r12_mode_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mode_o == $past(wr_mode_i)));
endmodule

// File: rtl/oc_cmp_shadow.sv
module oc_cmp_shadow #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_cmp_i,
  input  logic          wr_shadow_en_i,
  input  logic          shadow_en_i,
  input  logic          upd_i,
  output logic [CW-1:0] cmp_o
);
  logic [CW-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      buf_q <= '0;
    else if (wr_en_i) buf_q <= wr_cmp_i;
  end

  // direct write beats a same-edge update; update takes the old buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cmp_o <= '0;
    else if (wr_en_i && !wr_shadow_en_i)  cmp_o <= wr_cmp_i;
    else if (upd_i && shadow_en_i)        cmp_o <= buf_q;
  end

  a_r8_direct_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_shadow_en_i) |=> (cmp_o == $past(wr_cmp_i)));
  a_r7_update_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && shadow_en_i && !(wr_en_i && !wr_shadow_en_i)) |=> (cmp_o == $past(buf_q)));
  a_r7_hold_no_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !(wr_en_i && !wr_shadow_en_i)) |=> $stable(cmp_o));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW-1:0]   cnt_i,
  input  logic            cnt_up_i,
  input  logic            trig_i,
  input  oc_mode_e        mode_i,
  input  logic            fast_en_i,
  input  logic [IO_W-1:0] io_sel_i,
  input  logic [CW-1:0]   cmp_i,
  output logic            ref_o
);
  logic eq, lt, gt, pwm_a_lvl, fast_hit, ref_d;

  assign eq = (cnt_i == cmp_i);
  assign lt = (cnt_i <  cmp_i);
  assign gt = (cnt_i >  cmp_i);
  assign fast_hit = fast_en_i && trig_i;

  // PWM-A level; the fast path substitutes the equality level
  always_comb begin
    if (fast_hit) pwm_a_lvl = !cnt_up_i;
    else          pwm_a_lvl = cnt_up_i ? lt : !gt;
  end

  always_comb begin
    ref_d = ref_o;
    if (io_sel_i != IO_OUT) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode_i)
        OC_TIMING: ref_d = ref_o;
        OC_SET:    if (eq) ref_d = 1'b1;
        OC_CLR:    if (eq) ref_d = 1'b0;
        OC_TGL:    if (eq) ref_d = !ref_o;
        OC_LOW:    ref_d = 1'b0;
        OC_HIGH:   ref_d = 1'b1;
        OC_PWM_A:  ref_d = pwm_a_lvl;
        OC_PWM_B:  ref_d = !pwm_a_lvl;
        default:   ref_d = ref_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_o <= 1'b0;
    else         ref_o <= ref_d;
  end

  a_r11_input_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i != IO_OUT) |=> !ref_o);
  a_r3_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i == IO_OUT && mode_i == OC_LOW) |=> !ref_o);
  a_r3_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i == IO_OUT && mode_i == OC_HIGH) |=> ref_o);
  a_r6_timing_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i == IO_OUT && mode_i == OC_TIMING) |=> $stable(ref_o));
  a_r4_pwm_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i == IO_OUT && mode_i == OC_PWM_A && cnt_up_i && !trig_i)
      |=> (ref_o == $past(cnt_i < cmp_i)));
  a_r4_pwm_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i == IO_OUT && mode_i == OC_PWM_A && !cnt_up_i && !trig_i)
      |=> (ref_o == $past(cnt_i <= cmp_i)));
  a_r2_no_match_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i == IO_OUT && (mode_i == OC_SET || mode_i == OC_CLR || mode_i == OC_TGL)
     && (cnt_i != cmp_i)) |=> $stable(ref_o));
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_up_i,
  input  logic          upd_i,
  input  logic          trig_i,
  input  logic          ch_en_i,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_cmp_i,
  input  logic [2:0]    wr_mode_i,
  input  logic          wr_shadow_en_i,
  input  logic          wr_fast_en_i,
  input  logic [1:0]    wr_io_sel_i,
  output logic          ref_o
);
  oc_mode_e        mode;
  logic            shadow_en, fast_en;
  logic [IO_W-1:0] io_sel;
  logic [CW-1:0]   cmp_act;

  oc_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .ch_en_i, .wr_mode_i, .wr_shadow_en_i,
    .wr_fast_en_i, .wr_io_sel_i,
    .mode_o(mode), .shadow_en_o(shadow_en), .fast_en_o(fast_en), .io_sel_o(io_sel)
  );

  oc_cmp_shadow #(.CW(CW)) u_cmp (
    .clk_i, .rst_ni, .wr_en_i, .wr_cmp_i, .wr_shadow_en_i,
    .shadow_en_i(shadow_en), .upd_i, .cmp_o(cmp_act)
  );

  oc_ref_gen #(.CW(CW)) u_ref (
    .clk_i, .rst_ni, .cnt_i, .cnt_up_i, .trig_i,
    .mode_i(mode), .fast_en_i(fast_en), .io_sel_i(io_sel), .cmp_i(cmp_act),
    .ref_o
  );
endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [CW-1:0] cnt_i = '0, wr_cmp_i = '0;
  logic cnt_up_i = 1'b1, upd_i = 1'b0, trig_i = 1'b0, ch_en_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] wr_mode_i = '0;
  logic wr_shadow_en_i = 1'b0, wr_fast_en_i = 1'b0;
  logic [1:0] wr_io_sel_i = '0;
  logic ref_o;

  int checks = 0, errors = 0;
  bit chk_on = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  oc_channel #(.CW(CW)) dut (.*);

  // independent reference model
  logic [2:0] m_mode; logic m_sh, m_fast, m_ref; logic [1:0] m_io;
  logic [CW-1:0] m_buf, m_act;

  function automatic logic exp_ref(input logic [2:0] md, input logic [1:0] io,
      input logic fst, input logic trg, input logic up, input logic [CW-1:0] c,
      input logic [CW-1:0] k, input logic cur);
    logic p;
    if (io != 2'b00) return 1'b0;
    if (md[2:1] == 2'b11) begin
      if (fst && trg) p = up ? 1'b0 : 1'b1;
      else            p = up ? (c < k) : (c <= k);
      return md[0] ? !p : p;
    end
    case (md)
      3'b001: return (c == k) ? 1'b1 : cur;
      3'b010: return (c == k) ? 1'b0 : cur;
      3'b011: return (c == k) ? !cur : cur;
      3'b100: return 1'b0;
      3'b101: return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] md, input logic [1:0] io);
    if (io != 2'b00) return "R11";
    case (md)
      3'b000: return "R6";
      3'b001, 3'b010, 3'b011: return "R2";
      3'b100, 3'b101: return "R3";
      3'b110: return "R4/R9";
      default: return "R5/R9";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode <= 3'b000; m_sh <= 1'b0; m_fast <= 1'b0; m_io <= 2'b00;
      m_buf <= '0; m_act <= '0; m_ref <= 1'b0;
    end else begin
      m_ref <= exp_ref(m_mode, m_io, m_fast, trig_i, cnt_up_i, cnt_i, m_act, m_ref);
      if (wr_en_i) begin
        m_mode <= wr_mode_i; m_sh <= wr_shadow_en_i; m_fast <= wr_fast_en_i;
        m_buf <= wr_cmp_i;
        if (!ch_en_i) m_io <= wr_io_sel_i;
      end
      if (wr_en_i && !wr_shadow_en_i) m_act <= wr_cmp_i;
      else if (upd_i && m_sh)         m_act <= m_buf;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ref_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (chk_on && !done) check(tag_of(m_mode, m_io), ref_o, m_ref);

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] md, input logic [CW-1:0] c, input logic sh,
                    input logic fs, input logic [1:0] io);
    wr_en_i = 1'b1; wr_mode_i = md; wr_cmp_i = c; wr_shadow_en_i = sh;
    wr_fast_en_i = fs; wr_io_sel_i = io;
    step();
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    check("R1", ref_o, 1'b0);
    rst_ni = 1'b1;
    step();
    chk_on = 1'b1;
    // R1: active compare is 0 after reset -> set mode fires at cnt 0
    cnt_i = 0;
    wr(3'b001, 16'd0, 1'b1, 1'b0, 2'b00);  // shadowed write: active stays 0
    step();
    check("R1", ref_o, 1'b1);
    // R12/R3: force low effective on next edge
    wr(3'b100, 16'd0, 1'b0, 1'b0, 2'b00);
    step();
    check("R12", ref_o, 1'b0);
    // R8: direct compare load
    cnt_i = 5;
    wr(3'b001, 16'd5, 1'b0, 1'b0, 2'b00);
    step();
    check("R8", ref_o, 1'b1);
    // R7: shadowed value waits for update
    wr(3'b100, 16'd5, 1'b0, 1'b0, 2'b00);
    wr(3'b001, 16'd9, 1'b1, 1'b0, 2'b00);
    cnt_i = 9;
    step(3);
    check("R7", ref_o, 1'b0);
    upd_i = 1'b1; step(); upd_i = 1'b0;
    step();
    check("R7", ref_o, 1'b1);
    // R9: fast trigger in PWM-A counting up, cmp 10, cnt 3
    wr(3'b110, 16'd10, 1'b0, 1'b1, 2'b00);
    cnt_i = 3; cnt_up_i = 1'b1;
    step();
    check("R4", ref_o, 1'b1);
    trig_i = 1'b1; step(); trig_i = 1'b0;
    check("R9", ref_o, 1'b0);
    step();
    check("R9", ref_o, 1'b1);
    // R10: locked I/O select while enabled
    ch_en_i = 1'b1;
    wr(3'b101, 16'd0, 1'b0, 1'b0, 2'b01);
    step();
    check("R10", ref_o, 1'b1);
    ch_en_i = 1'b0;
    wr(3'b101, 16'd0, 1'b0, 1'b0, 2'b10);
    step();
    check("R11", ref_o, 1'b0);
    wr(3'b101, 16'd0, 1'b0, 1'b0, 2'b00);
    step();
    check("R3", ref_o, 1'b1);

    // constrained random
    cnt_i = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) cnt_up_i = ~cnt_up_i;
      if (cnt_up_i) cnt_i = (cnt_i >= 24) ? '0 : cnt_i + 1'b1;
      else          cnt_i = (cnt_i == 0) ? 16'd24 : cnt_i - 1'b1;
      upd_i  = ($urandom_range(0, 9) == 0);
      trig_i = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 31) == 0) ch_en_i = ~ch_en_i;
      wr_en_i = ($urandom_range(0, 11) == 0);
      wr_mode_i = 3'($urandom_range(0, 7));
      wr_cmp_i = 16'($urandom_range(0, 24));
      wr_shadow_en_i = 1'($urandom_range(0, 1));
      wr_fast_en_i = 1'($urandom_range(0, 1));
      wr_io_sel_i = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      step();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule